// File: doc/BRIEF.md
# Coulomb-Count Capacity Learning Engine

This block keeps the charge bookkeeping of a rechargeable-battery gauge. It receives count pulses for charge, discharge and self-discharge that have already been scaled and compensated elsewhere. It keeps four quantities: the available charge, a discharge tally, the learned full capacity and a counter of charges made since the capacity was last learned. From these it decides when a charge is genuine, when a discharge has gone from full to empty cleanly enough to become the new capacity, and when the external charger may run.

The available charge has a low byte and a high byte. A charge is genuine ("valid") only when an increment carries out of the low byte. The low byte is cleared whenever counting turns from down to up, so every valid charge represents 256 fresh counts. The learned capacity changes only at the first valid charge after the early empty warning, and only if the preceding discharge qualified. A charge-complete input can jump the available charge to full. In the second chemistry mode it jumps only to the 94 % mark.

Top module: `cap_learn_engine`

## Requirements
- R1: A valid charge is an up count whose increment carries from the low byte (bits 7:0) into the high byte. When an up count follows a down count, the low byte is zeroed before the increment, so a valid charge needs 256 consecutive up counts. `valid_chg_o` pulses for one cycle, registered with the new count.
- R2: The available charge never exceeds the learned capacity and never goes below 0. An up count at the capacity is ignored. An increment that would pass the capacity lands on the capacity.
- R3: The discharge tally increments on every discharge count, and on self-discharge counts only while the available charge is nonzero. It stops counting once the early empty warning is latched, saturates at FFFFh, and clears while the available charge equals the capacity with no count down in that cycle.
- R4: The first valid charge after the early empty warning clears the available charge to 0. If the discharge was qualified at that moment, the discharge tally is copied into the learned capacity in the same cycle.
- R5: A discharge is qualified (`vdq_o`) from the moment the available charge equals the capacity or charge-complete is seen. Qualification is lost on any of: a valid charge before the warning, 4096 self-discharge counts since full, the warning arriving while `cold_i` is high, or a capacity update.
- R6: The inaccuracy counter increments on valid charges that do not update the capacity, and saturates at 255. The inaccurate flag sets in the same cycle the counter reaches 64. A capacity update clears both the counter and the flag.
- R7: When a valid charge happens with the available charge at or above the threshold T = (capacity × 241) >> 8, it advances the inaccuracy counter only if the charge has dropped below T through a count down since the last such increment.
- R8: `chg_en_o` is high when the available charge is above T, or after a valid charge until the next discharge or self-discharge count; otherwise it is low.
- R9: While `done_i` is high, all count pulses are ignored. The available charge becomes the capacity when `nimh_i` is 0, and becomes max(charge, T) when `nimh_i` is 1.
- R10: Reset loads the capacity with the programmed full count. It clears the available charge, the discharge tally, the inaccuracy counter and the qualification, and sets the inaccurate and battery-replaced flags.
- R11: The battery-replaced flag clears when an up count brings the available charge to the capacity, or on a valid charge after the warning.
- R12: When several count pulses arrive in one cycle, only one is used: charge first, then discharge, then self-discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_cnt_i | input | 1 | One charge count |
| dis_cnt_i | input | 1 | One discharge count |
| sdis_cnt_i | input | 1 | One self-discharge count |
| done_i | input | 1 | Charge complete |
| edv1_i | input | 1 | Early empty warning |
| cold_i | input | 1 | Temperature below freezing |
| nimh_i | input | 1 | Chemistry select (1: stop at 94 %) |
| nac_o | output | NAC_W | Available charge |
| dcr_o | output | NAC_W | Discharge tally |
| lmd_o | output | NAC_W | Learned capacity |
| cpi_o | output | CPI_W | Inaccuracy counter |
| ci_o | output | 1 | Capacity inaccurate flag |
| vdq_o | output | 1 | Discharge qualified |
| brp_o | output | 1 | Battery replaced flag |
| chg_en_o | output | 1 | Charger enable |
| valid_chg_o | output | 1 | Valid charge pulse |

## Verification
A wrong direction bit or a low byte that is not zeroed appears in `nac_o` on the next up count. It also moves the cycle in which `valid_chg_o` pulses, so the carry boundaries show the fault within one 256-count burst. A mistake in qualification stays hidden until the charge that follows the warning: `lmd_o` then takes the tally when it should not, or keeps its old value when it should change. The bench therefore ends every learning scenario with that charge. Faults in the inaccuracy gating or saturation appear in `cpi_o` and `ci_o` at the valid charge that crosses 64 or 255, or at the valid charges made above the 94 % mark.

// File: rtl/cle_pkg.sv
package cle_pkg;

   typedef enum logic [1:0] {
      CLE_IDLE = 2'd0,
      CLE_UP   = 2'd1,
      CLE_DOWN = 2'd2,
      CLE_SELF = 2'd3
   } cle_op_e;

   // single count selected per cycle: charge, then discharge, then self (R12)
   function automatic cle_op_e cle_pick_op(input logic up, input logic dn,
                                           input logic sd, input logic hold);
      if (hold)    return CLE_IDLE;
      else if (up) return CLE_UP;
      else if (dn) return CLE_DOWN;
      else if (sd) return CLE_SELF;
      else         return CLE_IDLE;
   endfunction

endpackage

// File: rtl/cle_sat_ctr.sv
module cle_sat_ctr #(
   parameter int W   = 16,
   parameter int MAX = (1 << W) - 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] TOP = W'(MAX);

   initial begin
      assert (MAX > 0 && MAX < (1 << W)) else $error("cle_sat_ctr: MAX out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q_o <= '0;
      else if (clr_i)                q_o <= '0;
      else if (inc_i && q_o != TOP)  q_o <= q_o + W'(1);
   end
endmodule

// File: rtl/cle_thresh.sv
module cle_thresh #(
   parameter int W       = 16,
   parameter int NUM     = 241,
   parameter int SH      = 8,
   parameter bit USE_MUL = 1'b1
) (
   input  logic [W-1:0] cap_i,
   output logic [W-1:0] thr_o
);
   localparam int PW = W + SH;
   logic [PW-1:0] prod;

   generate
      if (USE_MUL) begin : g_mul
         assign prod = {{SH{1'b0}}, cap_i} * PW'(NUM);
      end else begin : g_shadd
         // 241 = 256 - 16 + 1
         initial begin
            assert (NUM == 241 && SH == 8) else $error("cle_thresh: shift-add form needs 241/256");
         end
         assign prod = ({{SH{1'b0}}, cap_i} << 8) - ({{SH{1'b0}}, cap_i} << 4)
                     + {{SH{1'b0}}, cap_i};
      end
   endgenerate

   assign thr_o = W'(prod >> SH);
endmodule

// File: rtl/cle_nac_core.sv
module cle_nac_core
   import cle_pkg::*;
#(
   parameter int W    = 16,
   parameter int LO_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cle_op_e      op_i,
   input  logic         done_i,
   input  logic         nimh_i,
   input  logic         zero_i,
   input  logic [W-1:0] cap_i,
   input  logic [W-1:0] thr_i,
   output logic [W-1:0] nac_o,
   output logic         carry_o,
   output logic         reach_o
);
   logic         up_q, up_d;
   logic [W-1:0] nac_d;
   logic [W:0]   cand;
   logic         room;

   initial begin
      assert (LO_W > 0 && LO_W < W) else $error("cle_nac_core: bad low-byte width");
   end

   always_comb begin
      // turning from down to up zeroes the low byte first (R1)
      if (up_q) cand = {1'b0, nac_o} + (W+1)'(1);
      else      cand = {1'b0, nac_o[W-1:LO_W], {LO_W{1'b0}}} + (W+1)'(1);
      room    = nac_o < cap_i;
      carry_o = (op_i == CLE_UP) && room && (cand <= {1'b0, cap_i})
                && (cand[LO_W-1:0] == '0);
      reach_o = (op_i == CLE_UP) && room && (cand >= {1'b0, cap_i});
   end

   always_comb begin
      nac_d = nac_o;
      up_d  = up_q;
      if (done_i) begin
         if (!nimh_i)            nac_d = cap_i;
         else if (nac_o < thr_i) nac_d = thr_i;
      end else begin
         unique case (op_i)
            CLE_UP: begin
               up_d = 1'b1;
               if (room) begin
                  if (zero_i)                   nac_d = '0;
                  else if (cand > {1'b0, cap_i}) nac_d = cap_i;
                  else                          nac_d = cand[W-1:0];
               end
            end
            CLE_DOWN, CLE_SELF: begin
               up_d = 1'b0;
               if (nac_o != '0) nac_d = nac_o - W'(1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nac_o <= '0;
         up_q  <= 1'b0;
      end else begin
         nac_o <= nac_d;
         up_q  <= up_d;
      end
   end
endmodule

// File: rtl/cap_learn_engine.sv
module cap_learn_engine
   import cle_pkg::*;
#(
   parameter int NAC_W    = 16,
   parameter int LO_W     = 8,
   parameter int CPI_W    = 8,
   parameter int CI_AT    = 64,
   parameter int SD_LIMIT = 4096,
   parameter int PFC      = 33792,
   parameter int THR_NUM  = 241,
   parameter int THR_SH   = 8,
   parameter bit THR_MUL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chg_cnt_i,
   input  logic             dis_cnt_i,
   input  logic             sdis_cnt_i,
   input  logic             done_i,
   input  logic             edv1_i,
   input  logic             cold_i,
   input  logic             nimh_i,
   output logic [NAC_W-1:0] nac_o,
   output logic [NAC_W-1:0] dcr_o,
   output logic [NAC_W-1:0] lmd_o,
   output logic [CPI_W-1:0] cpi_o,
   output logic             ci_o,
   output logic             vdq_o,
   output logic             brp_o,
   output logic             chg_en_o,
   output logic             valid_chg_o
);
   localparam int SD_W = $clog2(SD_LIMIT) + 1;
   localparam logic [SD_W-1:0]  SD_TOP  = SD_W'(SD_LIMIT);
   localparam logic [CPI_W-1:0] CI_PREV = CPI_W'(CI_AT - 1);

   initial begin
      assert (PFC > 0 && PFC < (1 << NAC_W)) else $error("cap_learn_engine: PFC out of range");
      assert (CI_AT > 0 && CI_AT < (1 << CPI_W)) else $error("cap_learn_engine: CI_AT out of range");
   end

   cle_op_e          op;
   logic [NAC_W-1:0] thr;
   logic             carry, reach, zero_nac, upd;
   logic             edv_q, armed_q, active_q;
   logic             full_now, down_now, dcr_inc, cpi_inc, sd_full, cold_hit;
   logic [SD_W-1:0]  sd_q;

   assign op       = cle_pick_op(chg_cnt_i, dis_cnt_i, sdis_cnt_i, done_i);
   assign down_now = (op == CLE_DOWN) || (op == CLE_SELF);
   assign full_now = (nac_o == lmd_o);
   assign zero_nac = carry && edv_q;
   assign upd      = zero_nac && vdq_o;
   assign sd_full  = (sd_q == SD_TOP);
   assign cold_hit = edv1_i && !edv_q && cold_i;
   assign dcr_inc  = !edv_q && ((op == CLE_DOWN) || (op == CLE_SELF && nac_o != '0));
   assign cpi_inc  = carry && !upd && ((nac_o < thr) || armed_q);

   cle_thresh #(.W(NAC_W), .NUM(THR_NUM), .SH(THR_SH), .USE_MUL(THR_MUL)) u_thr (
      .cap_i (lmd_o),
      .thr_o (thr)
   );

   cle_nac_core #(.W(NAC_W), .LO_W(LO_W)) u_nac (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .done_i  (done_i),
      .nimh_i  (nimh_i),
      .zero_i  (zero_nac),
      .cap_i   (lmd_o),
      .thr_i   (thr),
      .nac_o   (nac_o),
      .carry_o (carry),
      .reach_o (reach)
   );

   cle_sat_ctr #(.W(NAC_W)) u_dcr (
      .clk (clk), .rst_n (rst_n),
      .clr_i (full_now && !dcr_inc), .inc_i (dcr_inc), .q_o (dcr_o)
   );

   cle_sat_ctr #(.W(SD_W), .MAX(SD_LIMIT)) u_sd (
      .clk (clk), .rst_n (rst_n),
      .clr_i (full_now && !dcr_inc), .inc_i (op == CLE_SELF), .q_o (sd_q)
   );

   cle_sat_ctr #(.W(CPI_W)) u_cpi (
      .clk (clk), .rst_n (rst_n),
      .clr_i (upd), .inc_i (cpi_inc), .q_o (cpi_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lmd_o       <= NAC_W'(PFC);
         edv_q       <= 1'b0;
         vdq_o       <= 1'b0;
         ci_o        <= 1'b1;
         brp_o       <= 1'b1;
         armed_q     <= 1'b1;
         active_q    <= 1'b0;
         valid_chg_o <= 1'b0;
      end else begin
         valid_chg_o <= carry;
         if (upd) lmd_o <= dcr_o;

         if (carry)       edv_q <= 1'b0;
         else if (edv1_i) edv_q <= 1'b1;

         if (done_i)
            vdq_o <= 1'b1;
         else if (upd || (carry && !edv_q) || sd_full || cold_hit)
            vdq_o <= 1'b0;
         else if (full_now)
            vdq_o <= 1'b1;

         if (upd)                                  ci_o <= 1'b0;
         else if (cpi_inc && cpi_o >= CI_PREV)     ci_o <= 1'b1;

         if (reach || zero_nac) brp_o <= 1'b0;

         if (down_now && nac_o != '0 && nac_o <= thr) armed_q <= 1'b1;
         else if (cpi_inc && nac_o >= thr)             armed_q <= 1'b0;

         if (carry)         active_q <= 1'b1;
         else if (down_now) active_q <= 1'b0;
      end
   end

   assign chg_en_o = (nac_o > thr) || active_q;
endmodule

// File: rtl/cle_checker.sv
module cle_checker #(
   parameter int NAC_W   = 16,
   parameter int LO_W    = 8,
   parameter int CPI_W   = 8,
   parameter int CI_AT   = 64,
   parameter int THR_NUM = 241,
   parameter int THR_SH  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NAC_W-1:0] nac_o,
   input logic [NAC_W-1:0] dcr_o,
   input logic [NAC_W-1:0] lmd_o,
   input logic [CPI_W-1:0] cpi_o,
   input logic             ci_o,
   input logic             chg_en_o,
   input logic             valid_chg_o
);
   localparam int PW = NAC_W + THR_SH;
   logic [PW-1:0]    p;
   logic [NAC_W-1:0] t;
   assign p = {{THR_SH{1'b0}}, lmd_o} * PW'(THR_NUM);
   assign t = NAC_W'(p >> THR_SH);

   assert_nac_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nac_o <= lmd_o);

   assert_valid_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_chg_o |-> (nac_o[LO_W-1:0] == '0));

   assert_cap_moves_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_chg_o |-> $stable(lmd_o));

   assert_dcr_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_o == '1) |=> (dcr_o == '1 || dcr_o == '0));

   assert_cpi_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpi_o == '1) |=> (cpi_o == '1 || !ci_o));

   assert_ci_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpi_o >= CPI_W'(CI_AT)) |-> ci_o);

   assert_chg_en_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nac_o > t) |-> chg_en_o);
endmodule

bind cap_learn_engine cle_checker #(
   .NAC_W(NAC_W), .LO_W(LO_W), .CPI_W(CPI_W), .CI_AT(CI_AT),
   .THR_NUM(THR_NUM), .THR_SH(THR_SH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .nac_o(nac_o), .dcr_o(dcr_o), .lmd_o(lmd_o),
   .cpi_o(cpi_o), .ci_o(ci_o), .chg_en_o(chg_en_o), .valid_chg_o(valid_chg_o)
);

// File: tb/cap_learn_engine_bench.sv
module cap_learn_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CAP0       = 1070;   // threshold (1070*241)>>8 = 1007

   logic clk = 1'b0, rst_n = 1'b0;
   logic chg = 0, dis = 0, sdis = 0, done = 0, edv = 0, cold = 0, nimh = 0;
   logic [15:0] nac, dcr, lmd;
   logic [7:0]  cpi;
   logic ci, vdq, brp, chg_en, vld;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_learn_engine #(.PFC(CAP0)) u_cap_learn_engine (
      .clk(clk), .rst_n(rst_n), .chg_cnt_i(chg), .dis_cnt_i(dis), .sdis_cnt_i(sdis),
      .done_i(done), .edv1_i(edv), .cold_i(cold), .nimh_i(nimh),
      .nac_o(nac), .dcr_o(dcr), .lmd_o(lmd), .cpi_o(cpi), .ci_o(ci), .vdq_o(vdq),
      .brp_o(brp), .chg_en_o(chg_en), .valid_chg_o(vld)
   );

   // op: 0 charge, 1 discharge, 2 self-discharge, 3 charge complete, 4 warning
   localparam int NV = 13;
   localparam int TV_OP [NV]  = '{0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 1, 2, 1};
   localparam int TV_N  [NV]  = '{255, 1, 900, 100, 1, 255, 10, 256, 20, 256, 1024, 5, 3};
   localparam int TV_NAC[NV]  = '{255, 256, 1070, 970, 769, 1024, 1014, 1024, 1004, 1024, 0, 0, 0};
   localparam int TV_DCR[NV]  = '{0, 0, 0, 100, 100, 100, 110, 110, 130, 130, 1154, 1154, 1157};
   localparam int TV_CPI[NV]  = '{0, 1, 4, 4, 4, 5, 5, 5, 5, 6, 6, 6, 6};

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic burst(input int op, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chg = (op == 0); dis = (op == 1); sdis = (op == 2);
         done = (op == 3); edv = (op == 4);
      end
      @(negedge clk);
      chg = 0; dis = 0; sdis = 0; done = 0; edv = 0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset nac", nac, 0);
      chk("R10 reset lmd", lmd, CAP0);
      chk("R10 reset cpi", cpi, 0);
      chk("R10 reset ci", ci, 1);
      chk("R10 reset brp", brp, 1);
      chk("R10 reset vdq", vdq, 0);
      chk("R8 reset chg_en", chg_en, 0);
      rst_n = 1;
      @(negedge clk);

      // R1 R2 R3 R7: vector walk
      for (int v = 0; v < NV; v++) begin
         burst(TV_OP[v], TV_N[v]);
         chk($sformatf("R1/R2 vec%0d nac", v), nac, TV_NAC[v]);
         chk($sformatf("R3 vec%0d dcr", v), dcr, TV_DCR[v]);
         chk($sformatf("R7 vec%0d cpi", v), cpi, TV_CPI[v]);
      end
      chk("R11 brp after reaching full", brp, 0);

      // R12: simultaneous charge and discharge -> charge only
      @(negedge clk); chg = 1; dis = 1;
      @(negedge clk); chg = 0; dis = 0;
      @(negedge clk);
      chk("R12 charge wins", nac, 1);
      chk("R12 no tally", dcr, 1157);
      burst(1, 1);

      // R4 R5: qualified full-to-empty learning
      burst(3, 1);
      chk("R9 done full", nac, CAP0);
      chk("R5 vdq after done", vdq, 1);
      chk("R3 tally cleared at full", dcr, 0);
      burst(1, 1070);
      burst(2, 3);
      chk("R3 self ignored at empty", dcr, 1070);
      burst(1, 30);
      burst(4, 1);
      burst(0, 255);
      chk("R1 no valid at 255", lmd, CAP0);
      burst(0, 1);
      chk("R4 learned", lmd, 1100);
      chk("R4 nac cleared", nac, 0);
      chk("R6 cpi cleared", cpi, 0);
      chk("R6 ci cleared", ci, 0);
      chk("R5 vdq after update", vdq, 0);
      chk("R8 chg_en after valid", chg_en, 1);

      // R9 both chemistry modes (threshold now 1035)
      burst(3, 1);
      chk("R9 nickel done", nac, 1100);
      nimh = 1;
      burst(1, 200);
      chk("R8 chg_en low", chg_en, 0);
      burst(3, 1);
      chk("R9 raised to 94%", nac, 1035);
      chk("R8 equal to threshold", chg_en, 0);
      nimh = 0;

      // R5: cold warning blocks learning
      burst(3, 1);
      burst(1, 500);
      cold = 1; burst(4, 1); cold = 0;
      chk("R5 cold clears vdq", vdq, 0);
      burst(0, 256);
      chk("R4 no update when unqualified", lmd, 1100);
      chk("R4 nac cleared unqualified", nac, 0);
      chk("R6 cpi counts", cpi, 1);

      // R5: self-discharge limit
      burst(3, 1);
      burst(2, 4095);
      chk("R5 vdq at 4095", vdq, 1);
      chk("R3 tally from self", dcr, 1100);
      burst(2, 1);
      chk("R5 vdq at 4096", vdq, 0);
      burst(4, 1);
      burst(0, 256);
      chk("R4 no update after limit", lmd, 1100);
      chk("R6 cpi 2", cpi, 2);

      // R6: flag at 64, saturation at 255
      for (int k = 0; k < 61; k++) begin burst(0, 256); burst(1, 256); end
      chk("R6 cpi 63", cpi, 63);
      chk("R6 ci below limit", ci, 0);
      burst(0, 256); burst(1, 256);
      chk("R6 ci at 64", ci, 1);
      for (int k = 0; k < 191; k++) begin burst(0, 256); burst(1, 256); end
      chk("R6 cpi 255", cpi, 255);
      burst(0, 256);
      chk("R6 cpi saturates", cpi, 255);

      // R10 reset again
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk("R10 second reset lmd", lmd, CAP0);
      chk("R10 second reset ci", ci, 1);
      chk("R10 second reset brp", brp, 1);
      chk("R10 second reset cpi", cpi, 0);
      finish_run();
   end
endmodule